// File: doc/BRIEF.md
# State Breakpoint and Signature Recorder

This block sits beside the state register of a larger design and watches it at full clock rate. In every cycle where the watched design is allowed to run, it reduces the whole state vector to a short signature and writes that signature into a small ring of recent entries. A complete state vector, shifted in by a host over a one-bit serial port, serves as the breakpoint target. Once the breakpoint is armed and the live state equals the target exactly, the block withdraws the design's run enable and keeps a copy of the matching state.

With the design frozen, the host shifts out the captured state and the recent signature history through the same serial port. Each signature depends only on a state that existed one cycle earlier. An off-chip tool can use that history to narrow down which states came before the halt, load one of them as the next target, rerun the design and repeat. The signature function is chosen at build time. It is either a GF(2) matrix product over every state bit or a fixed selection of state bits.

Top module: `state_trap`

## Requirements
- R1: With the default hash variant, signature bit j is the XOR of every state bit k for which (((j+1)*(k+1)*37 + 5*j) mod 251) < 125.
- R2: In every cycle with run_ok high, the signature of live_state is written as the newest entry of a ring of H entries, and the oldest entry is dropped once the ring is full. While run_ok is low, the ring does not change.
- R3: With sh_sel = 2, sh_dout presents the history newest entry first and each entry LSB first. Each sh_en cycle advances one bit. An entry that was never written, and any bit past H entries, reads as 0. The read cursor returns to the newest entry at every breakpoint hit.
- R4: With sh_sel = 0, every sh_en cycle shifts the target right and sh_din enters at the MSB, so SW shifts load the target LSB first. While sh_sel = 0, sh_dout shows target bit 0.
- R5: If armed is high, run_ok is high and live_state equals the target in cycle N, then in cycle N+1 run_ok is low, trap_hit is high for that single cycle and armed is low. The captured state equals live_state from cycle N.
- R6: While armed is low, a state match never halts the design or raises trap_hit.
- R7: After a halt, run_ok stays low until resume_req is sampled high. It returns high in the cycle after that.
- R8: With sh_sel = 1, sh_dout shows captured bit 0 and every sh_en cycle shifts the capture right, with sh_din entering at the MSB. SW shifts therefore read the captured state LSB first.
- R9: sh_en with sh_sel = 3 changes neither the target, the capture nor the history cursor.
- R10: Reset clears armed, the halt and the history occupancy, so run_ok is high and armed and trap_hit are low. The target register keeps its contents across reset.
- R11: A cycle with arm_req high sets armed in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the watched design |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| live_state | input | SW | Current state vector of the watched design |
| arm_req | input | 1 | Arms the breakpoint |
| resume_req | input | 1 | Releases a halt |
| sh_en | input | 1 | Serial shift strobe |
| sh_sel | input | 2 | Serial target: 0 breakpoint target, 1 captured state, 2 history, 3 none |
| sh_din | input | 1 | Serial data into the selected register |
| run_ok | output | 1 | Run enable for the watched design, low while halted |
| armed | output | 1 | Breakpoint armed |
| trap_hit | output | 1 | One-cycle pulse on the first halted cycle |
| sh_dout | output | 1 | Serial data from the selected register |

## Verification
The hardest case to reach is a history ring that is only partly filled at the moment of a hit, because the ring fills within a few cycles of running. The stimulus loads the target first and then pulses reset, which the target survives. It holds arm_req and the design model's step enable high through reset, so the breakpoint is armed on the first running cycle. The match then lands two steps later, leaving three written entries and one or more empty slots that must read as zeros. The one-cycle halt delay is checked every cycle against a model of the design, which keeps advancing for exactly one step after the match.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic [1:0] {
    SEL_TGT  = 2'd0,
    SEL_CAP  = 2'd1,
    SEL_HIST = 2'd2,
    SEL_IDLE = 2'd3
  } sh_sel_e;

  localparam int MIX_MUL = 37;
  localparam int MIX_ROW = 5;
  localparam int MIX_MOD = 251;
  localparam int MIX_CUT = 125;

  // one entry of the GF(2) hash matrix: row j (signature bit), column k (state bit)
  function automatic bit mix_tap(input int j, input int k);
    return (((j + 1) * (k + 1) * MIX_MUL + MIX_ROW * j) % MIX_MOD) < MIX_CUT;
  endfunction

endpackage

// File: rtl/strap_sig.sv
module strap_sig
  import strap_pkg::*;
#(
  parameter int SW   = 128,
  parameter int GW   = 16,
  parameter int KIND = 1
) (
  input  logic [SW-1:0] st,
  output logic [GW-1:0] sig
);

  localparam int STRIDE = SW / GW;

  generate
    if (KIND == 1) begin : g_hash
      always_comb begin
        for (int j = 0; j < GW; j++) begin
          logic acc;
          acc = 1'b0;
          for (int k = 0; k < SW; k++) begin
            if (mix_tap(j, k)) acc = acc ^ st[k];
          end
          sig[j] = acc;
        end
      end
    end else begin : g_pick
      for (genvar j = 0; j < GW; j++) begin : g_bit
        assign sig[j] = st[j * STRIDE];
      end
    end
  endgenerate

endmodule

// File: rtl/strap_hist.sv
module strap_hist #(
  parameter int GW = 16,
  parameter int H  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rec_en,
  input  logic [GW-1:0] sig_in,
  input  logic          rd_restart,
  input  logic          rd_step,
  output logic          rd_bit
);

  localparam int AW = $clog2(H);
  localparam int BW = (GW > 1) ? $clog2(GW) : 1;

  logic [GW-1:0] ring [H];
  logic [AW-1:0] wptr;
  logic          full;
  logic [AW:0]   rd_ent;
  logic [BW-1:0] rd_bitc;
  logic [AW:0]   occ;
  logic [AW-1:0] rd_addr;
  logic          rd_valid;
  logic          rd_done;

  initial begin
    if ((1 << AW) != H || H < 2) $error("strap_hist: H must be a power of two, at least 2");
  end

  always_ff @(posedge clk) begin
    if (rec_en) ring[wptr] <= sig_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      full <= 1'b0;
    end else if (rec_en) begin
      wptr <= wptr + AW'(1);
      if (wptr == AW'(H - 1)) full <= 1'b1;
    end
  end

  assign occ      = full ? (AW + 1)'(H) : {1'b0, wptr};
  assign rd_addr  = wptr - AW'(1) - rd_ent[AW-1:0];
  assign rd_valid = rd_ent < occ;
  assign rd_done  = rd_ent >= (AW + 1)'(H);
  assign rd_bit   = rd_valid ? ring[rd_addr][rd_bitc] : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n || rd_restart) begin
      rd_ent  <= '0;
      rd_bitc <= '0;
    end else if (rd_step && !rd_done) begin
      if (rd_bitc == BW'(GW - 1)) begin
        rd_bitc <= '0;
        rd_ent  <= rd_ent + (AW + 1)'(1);
      end else begin
        rd_bitc <= rd_bitc + BW'(1);
      end
    end
  end

  AST_HIST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_en |=> $stable(wptr) && $stable(full)); // R2
  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> full); // R2
  AST_CURSOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_step && !rd_restart |=> $stable(rd_ent) && $stable(rd_bitc)); // R9

endmodule

// File: rtl/strap_trig.sv
module strap_trig #(
  parameter int SW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] live,
  input  logic          arm_req,
  input  logic          resume_req,
  input  logic          tgt_shift,
  input  logic          tgt_din,
  input  logic          cap_shift,
  input  logic          cap_din,
  output logic          match_w,
  output logic          halt_q,
  output logic          armed_q,
  output logic          hit_q,
  output logic          tgt_lsb,
  output logic          cap_lsb
);

  logic [SW-1:0] tgt_q;
  logic [SW-1:0] cap_q;
  logic          eq_w;

  assign eq_w    = (live == tgt_q);
  assign match_w = armed_q && !halt_q && eq_w;
  assign tgt_lsb = tgt_q[0];
  assign cap_lsb = cap_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_q  <= 1'b0;
      armed_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      hit_q <= match_w;
      if (match_w) begin
        halt_q  <= 1'b1;
        armed_q <= 1'b0;
      end else begin
        if (halt_q && resume_req) halt_q <= 1'b0;
        if (arm_req) armed_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (tgt_shift) tgt_q <= {tgt_din, tgt_q[SW-1:1]};
  end

  always_ff @(posedge clk) begin
    if (match_w)        cap_q <= live;
    else if (cap_shift) cap_q <= {cap_din, cap_q[SW-1:1]};
  end

  AST_MATCH_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    match_w |=> halt_q && !armed_q); // R5
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q && !resume_req |=> halt_q); // R7
  AST_ARMED_BEFORE_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_q) |-> $past(armed_q)); // R6
  AST_TGT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_shift |=> $stable(tgt_q)); // R9
  AST_ARM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    arm_req && !match_w |=> armed_q); // R11

endmodule

// File: rtl/state_trap.sv
module state_trap
  import strap_pkg::*;
#(
  parameter int SW   = 128,
  parameter int GW   = 16,
  parameter int H    = 8,
  parameter int KIND = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] live_state,
  input  logic          arm_req,
  input  logic          resume_req,
  input  logic          sh_en,
  input  logic [1:0]    sh_sel,
  input  logic          sh_din,
  output logic          run_ok,
  output logic          armed,
  output logic          trap_hit,
  output logic          sh_dout
);

  sh_sel_e       sel_w;
  logic [GW-1:0] sig_w;
  logic          match_w;
  logic          halt_w;
  logic          tgt_shift_w;
  logic          cap_shift_w;
  logic          hist_step_w;
  logic          tgt_lsb_w;
  logic          cap_lsb_w;
  logic          hist_bit_w;

  assign sel_w       = sh_sel_e'(sh_sel);
  assign tgt_shift_w = sh_en && (sel_w == SEL_TGT);
  assign cap_shift_w = sh_en && (sel_w == SEL_CAP);
  assign hist_step_w = sh_en && (sel_w == SEL_HIST);
  assign run_ok      = !halt_w;

  strap_sig #(.SW(SW), .GW(GW), .KIND(KIND)) i_sig (
    .st  (live_state),
    .sig (sig_w)
  );

  strap_trig #(.SW(SW)) i_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .live       (live_state),
    .arm_req    (arm_req),
    .resume_req (resume_req),
    .tgt_shift  (tgt_shift_w),
    .tgt_din    (sh_din),
    .cap_shift  (cap_shift_w),
    .cap_din    (sh_din),
    .match_w    (match_w),
    .halt_q     (halt_w),
    .armed_q    (armed),
    .hit_q      (trap_hit),
    .tgt_lsb    (tgt_lsb_w),
    .cap_lsb    (cap_lsb_w)
  );

  strap_hist #(.GW(GW), .H(H)) i_hist (
    .clk        (clk),
    .rst_n      (rst_n),
    .rec_en     (run_ok),
    .sig_in     (sig_w),
    .rd_restart (match_w),
    .rd_step    (hist_step_w),
    .rd_bit     (hist_bit_w)
  );

  always_comb begin
    unique case (sel_w)
      SEL_TGT:  sh_dout = tgt_lsb_w;
      SEL_CAP:  sh_dout = cap_lsb_w;
      SEL_HIST: sh_dout = hist_bit_w;
      default:  sh_dout = 1'b0;
    endcase
  end

  AST_HIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_hit |=> !trap_hit); // R5
  AST_HIT_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    trap_hit |-> !run_ok); // R5
  AST_RESUME_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    !run_ok && resume_req && !trap_hit |=> run_ok); // R7

endmodule

// File: tb/test_state_trap.sv
module test_state_trap;

  localparam int SW = 128;
  localparam int GW = 16;
  localparam int H  = 8;
  localparam logic [SW-1:0] SEED = 128'h0123_4567_89AB_CDEF_F00D_CAFE_1357_9BDF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] s;
  logic          go = 1'b0;
  logic          arm_req = 1'b0, resume_req = 1'b0;
  logic          sh_en = 1'b0, sh_din = 1'b0;
  logic [1:0]    sh_sel = 2'd3;
  logic          run_ok, armed, trap_hit, sh_dout;

  int total = 0, bad = 0, hit_cnt = 0;
  bit done = 0;
  logic [SW-1:0] tgt_model = '0;
  logic          prev_match = 1'b0;

  typedef struct { logic b; string tag; } exp_t;
  exp_t          sbq[$];
  logic [GW-1:0] rec[$];

  always #5 clk = ~clk;

  state_trap #(.SW(SW), .GW(GW), .H(H), .KIND(1)) i_state_trap (
    .clk(clk), .rst_n(rst_n), .live_state(s), .arm_req(arm_req),
    .resume_req(resume_req), .sh_en(sh_en), .sh_sel(sh_sel), .sh_din(sh_din),
    .run_ok(run_ok), .armed(armed), .trap_hit(trap_hit), .sh_dout(sh_dout)
  );

  function automatic logic [63:0] xs(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  function automatic logic [SW-1:0] nxt(input logic [SW-1:0] v);
    logic [63:0] lo, hi;
    lo = xs(v[63:0]);
    hi = xs(v[127:64] ^ lo);
    return {hi, lo};
  endfunction

  function automatic logic [SW-1:0] adv(input logic [SW-1:0] v, input int n);
    logic [SW-1:0] r;
    r = v;
    for (int i = 0; i < n; i++) r = nxt(r);
    return r;
  endfunction

  // R1 restated: residues walked incrementally per row, parity of the masked state
  function automatic logic [GW-1:0] bsig(input logic [SW-1:0] v);
    logic [GW-1:0] r;
    for (int j = 0; j < GW; j++) begin
      logic [SW-1:0] mask;
      int res, step;
      step = ((j + 1) * 37) % 251;
      res  = (step + 5 * j) % 251;
      for (int k = 0; k < SW; k++) begin
        mask[k] = (res < 125);
        res = (res + step) % 251;
      end
      r[j] = ^(v & mask);
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) s <= SEED;
    else if (run_ok && go) s <= nxt(s);
  end

  task automatic chk(input bit ok, input string tag, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: records history, checks halt timing, pops the scoreboard
  always begin
    @(negedge clk);
    #1;
    if (!rst_n) begin
      rec.delete();
      prev_match = 1'b0;
    end else begin
      chk(trap_hit === prev_match, "R5 hit timing", SW'(trap_hit), SW'(prev_match));
      if (trap_hit) begin
        hit_cnt++;
        chk(run_ok === 1'b0, "R5 run_ok low on hit", SW'(run_ok), '0);
      end
      prev_match = armed && run_ok && (s == tgt_model);
      if (run_ok) rec.push_front(bsig(s));
    end
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      chk(sh_dout === e.b, e.tag, SW'(sh_dout), SW'(e.b));
    end
  end

  task automatic load_tgt(input logic [SW-1:0] v);
    for (int i = 0; i < SW; i++) begin
      @(negedge clk);
      sh_sel = 2'd0; sh_en = 1'b1; sh_din = v[i];
    end
    @(negedge clk);
    sh_en = 1'b0; sh_din = 1'b0;
    tgt_model = v;
  endtask

  task automatic drive_bit(input logic [1:0] sel, input logic expb, input string tag);
    @(negedge clk);
    sh_sel = sel; sh_en = 1'b1; sh_din = 1'b0;
    sbq.push_back('{b: expb, tag: tag});
  endtask

  task automatic end_shift();
    @(negedge clk);
    sh_en = 1'b0;
    #2;
  endtask

  task automatic unload_cap(input logic [SW-1:0] v);
    for (int i = 0; i < SW; i++) drive_bit(2'd1, v[i], "R8 capture unload");
    end_shift();
  endtask

  task automatic unload_hist();
    for (int e = 0; e <= H; e++) begin
      logic [GW-1:0] ent;
      ent = (e < H && e < rec.size()) ? rec[e] : '0;
      for (int b = 0; b < GW; b++) drive_bit(2'd2, ent[b], "R3 R2 R1 history unload");
    end
    end_shift();
  endtask

  task automatic wait_halt(output bit got);
    got = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      #2;
      if (!run_ok) begin got = 1; break; end
    end
  endtask

  initial begin
    logic [SW-1:0] t1, t2, t3;
    bit got;
    int hits_before;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(run_ok === 1'b1, "R10 run_ok after reset", SW'(run_ok), SW'(1));
    chk(armed === 1'b0, "R10 armed after reset", SW'(armed), '0);
    chk(trap_hit === 1'b0, "R10 trap_hit after reset", SW'(trap_hit), '0);

    // scenario 1: full history, halt at ten steps
    t1 = adv(SEED, 10);
    load_tgt(t1);
    @(negedge clk); sh_sel = 2'd0; #2;
    chk(sh_dout === t1[0], "R4 target bit0 on sh_dout", SW'(sh_dout), SW'(t1[0]));
    @(negedge clk); arm_req = 1'b1;
    @(negedge clk); arm_req = 1'b0; #2;
    chk(armed === 1'b1, "R11 armed after arm_req", SW'(armed), SW'(1));
    go = 1'b1;
    wait_halt(got);
    chk(got, "R5 halt reached", SW'(got), SW'(1));
    chk(armed === 1'b0, "R5 armed cleared", SW'(armed), '0);
    repeat (20) @(negedge clk);
    #2;
    chk(run_ok === 1'b0, "R7 halt persists", SW'(run_ok), '0);
    chk(s === nxt(t1), "R5 design froze one step after match", s, nxt(t1));
    // R9: idle-mode shifts touch nothing
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); sh_sel = 2'd3; sh_en = 1'b1; sh_din = 1'b1;
    end
    end_shift();
    unload_cap(t1);
    unload_hist();
    @(negedge clk); sh_sel = 2'd0; #2;
    chk(sh_dout === t1[0], "R9 target kept after other modes", SW'(sh_dout), SW'(t1[0]));

    // resume
    @(negedge clk); resume_req = 1'b1;
    @(negedge clk); resume_req = 1'b0; #2;
    chk(run_ok === 1'b1, "R7 run_ok after resume", SW'(run_ok), SW'(1));

    // scenario 2: match while disarmed
    @(negedge clk); go = 1'b0;
    #2;
    t2 = adv(s, 5);
    load_tgt(t2);
    hits_before = hit_cnt;
    go = 1'b1;
    repeat (30) @(negedge clk);
    #2;
    chk(run_ok === 1'b1, "R6 no halt when disarmed", SW'(run_ok), SW'(1));
    chk(hit_cnt == hits_before, "R6 no trap_hit when disarmed", SW'(hit_cnt), SW'(hits_before));

    // scenario 3: partly filled history after reset, target survives reset
    @(negedge clk); go = 1'b0;
    t3 = adv(SEED, 2);
    load_tgt(t3);
    @(negedge clk); rst_n = 1'b0; go = 1'b1; arm_req = 1'b1;
    repeat (2) @(negedge clk);
    sh_sel = 2'd0; #2;
    chk(sh_dout === t3[0], "R10 target kept through reset", SW'(sh_dout), SW'(t3[0]));
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); arm_req = 1'b0;
    wait_halt(got);
    chk(got, "R10 R5 halt after reset", SW'(got), SW'(1));
    chk(rec.size() == 3, "R2 three entries since reset", SW'(rec.size()), SW'(3));
    unload_cap(t3);
    unload_hist();

    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule